// File: doc/BRIEF.md
# APB Protocol Checker

This block is a passive observer for an APB bus linking one requester to one completer. Each clock it takes the select, enable, ready, address, direction and write-data lines as inputs and works out which bus phase is in progress: idle, setup or access. It remembers the phase of the previous cycle and flags phase sequences the protocol forbids. While a transfer is stalled in its access phase, it compares the address, direction and (on writes) write data against values captured at the start of the transfer. It never drives the bus.

Each kind of violation has its own sticky flag. A one-cycle pulse marks every cycle that broke at least one rule. A wrapping counter tallies completed transfers. All outputs are registered, so a violation or completion in cycle N shows on the outputs in cycle N+1. This block uses a synchronous active-high reset, so it can sit in simulation next to a bus under test or go into an FPGA debug build.

Top module: `apb_protocol_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, all bits of `err_sticky`, `err_pulse` and `xfer_count` go to zero on the next cycle, and the remembered previous phase becomes idle.
- R2: The phase comes from {select, enable}: 00 is idle, 10 is setup and 11 is access. Encoding 01 is illegal and sets `err_sticky[0]`.
- R3: A cycle that follows a setup cycle and is not an access cycle sets `err_sticky[1]`.
- R4: An access cycle whose previous cycle was idle or illegal sets `err_sticky[2]`.
- R5: A cycle that follows an access cycle with ready low and is not itself an access cycle sets `err_sticky[3]`.
- R6: In an access cycle that continues a transfer, address or direction differing from the values seen in that transfer's setup cycle sets `err_sticky[4]`. A transfer is continued when the previous cycle was setup, or was access with ready low.
- R7: In such a continuing access cycle of a write transfer (direction 1 in setup), write data differing from the setup value sets `err_sticky[5]`. On read transfers, write data is not compared.
- R8: An access cycle that directly follows an access cycle with ready high sets `err_sticky[6]`.
- R9: `xfer_count` rises by one in the cycle after each access cycle with ready high and wraps modulo 2^CNT_W. Otherwise it holds.
- R10: Error flags appear one cycle after the violating cycle and stay set until reset.
- R11: `err_pulse` is high in the cycle after any cycle with at least one violation, and low after a cycle with none.
- R12: During idle cycles, changes on ready, address, direction and write data raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Observed completer select |
| bus_enable | input | 1 | Observed enable |
| bus_ready | input | 1 | Observed completer ready |
| bus_addr | input | ADDR_W | Observed address |
| bus_write | input | 1 | Observed direction, 1 for write |
| bus_wdata | input | DATA_W | Observed write data |
| err_sticky | output | 7 | Sticky violation flags, bit meanings in R2 to R8 |
| err_pulse | output | 1 | One-cycle marker of a violating cycle |
| xfer_count | output | CNT_W | Completed-transfer count |

## Verification
The bench builds the checker with ADDR_W=8, DATA_W=16 and CNT_W=4. The narrow counter lets a burst of seventeen back-to-back transfers push the count past its wrap point within a short run. The narrow data paths keep the hand-written address and data changes easy to read while still covering direction and data mismatches separately. Each violation is provoked on its own after a reset, so every flag bit and the pulse are matched one cycle after the offending bus cycle.

// File: rtl/apbmon_pkg.sv
package apbmon_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_ILLEGAL = 2'b01,
    PH_SETUP   = 2'b10,
    PH_ACCESS  = 2'b11
  } phase_e;

  localparam int ERR_N        = 7;
  localparam int ERR_ENCODING = 0;
  localparam int ERR_SETUPLEN = 1;
  localparam int ERR_ENTRY    = 2;
  localparam int ERR_EARLY    = 3;
  localparam int ERR_CTRL     = 4;
  localparam int ERR_WDATA    = 5;
  localparam int ERR_POST     = 6;

  function automatic phase_e decode_phase(input logic sel, input logic en);
    phase_e ph;
    case ({sel, en})
      2'b00:   ph = PH_IDLE;
      2'b10:   ph = PH_SETUP;
      2'b11:   ph = PH_ACCESS;
      default: ph = PH_ILLEGAL;
    endcase
    return ph;
  endfunction

endpackage

// File: rtl/apbmon_phase_track.sv
module apbmon_phase_track
  import apbmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             en,
  input  logic             ready,
  output phase_e           cur_phase,
  output logic             in_xfer,
  output logic [ERR_N-1:0] seq_err
);

  phase_e prev_phase;
  logic   prev_ready;

  assign cur_phase = decode_phase(sel, en);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_phase <= PH_IDLE;
      prev_ready <= 1'b0;
    end else begin
      prev_phase <= cur_phase;
      prev_ready <= ready;
    end
  end

  logic prev_stalled;
  logic prev_done;
  assign prev_stalled = (prev_phase == PH_ACCESS) && !prev_ready;
  assign prev_done    = (prev_phase == PH_ACCESS) && prev_ready;

  assign in_xfer = (cur_phase == PH_ACCESS) &&
                   ((prev_phase == PH_SETUP) || prev_stalled);

  always_comb begin
    seq_err               = '0;
    seq_err[ERR_ENCODING] = (cur_phase == PH_ILLEGAL);
    seq_err[ERR_SETUPLEN] = (prev_phase == PH_SETUP) && (cur_phase != PH_ACCESS);
    seq_err[ERR_ENTRY]    = (cur_phase == PH_ACCESS) &&
                            ((prev_phase == PH_IDLE) || (prev_phase == PH_ILLEGAL));
    seq_err[ERR_EARLY]    = prev_stalled && (cur_phase != PH_ACCESS);
    seq_err[ERR_POST]     = prev_done && (cur_phase == PH_ACCESS);
  end

  // R6: a continuing access cycle can only follow setup or a stalled access
  p_cont_source_r6: assert property (@(posedge clk) disable iff (rst)
    in_xfer |-> !seq_err[ERR_ENTRY] && !seq_err[ERR_POST]);

endmodule

// File: rtl/apbmon_hold_check.sv
module apbmon_hold_check
  import apbmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            cur_phase,
  input  logic              in_xfer,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_mis,
  output logic              wdata_mis
);

  logic [ADDR_W-1:0] cap_addr;
  logic              cap_write;
  logic [DATA_W-1:0] cap_wdata;
  logic              cap_en;

  assign cap_en = (cur_phase == PH_SETUP) ||
                  ((cur_phase == PH_ACCESS) && !in_xfer);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr  <= '0;
      cap_write <= 1'b0;
      cap_wdata <= '0;
    end else if (cap_en) begin
      cap_addr  <= addr;
      cap_write <= write;
      cap_wdata <= wdata;
    end
  end

  assign ctrl_mis  = in_xfer && ((addr != cap_addr) || (write != cap_write));
  assign wdata_mis = in_xfer && cap_write && (wdata != cap_wdata);

  // R7: a data mismatch is only reported on a transfer that began as a write
  p_wdata_write_only_r7: assert property (@(posedge clk) disable iff (rst)
    (cur_phase == PH_SETUP && !write) |=> (!wdata_mis || cur_phase != PH_ACCESS));

endmodule

// File: rtl/apbmon_xfer_counter.sv
module apbmon_xfer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + ONE;
  end

endmodule

// File: rtl/apb_protocol_monitor.sv
module apb_protocol_monitor
  import apbmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [ERR_N-1:0]  err_sticky,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  xfer_count
);

  phase_e           cur_phase;
  logic             in_xfer;
  logic [ERR_N-1:0] seq_err;
  logic             ctrl_mis;
  logic             wdata_mis;
  logic [ERR_N-1:0] err_now;

  apbmon_phase_track u_phase (
    .clk       (clk),
    .rst       (rst),
    .sel       (bus_sel),
    .en        (bus_enable),
    .ready     (bus_ready),
    .cur_phase (cur_phase),
    .in_xfer   (in_xfer),
    .seq_err   (seq_err)
  );

  apbmon_hold_check #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .cur_phase (cur_phase),
    .in_xfer   (in_xfer),
    .addr      (bus_addr),
    .write     (bus_write),
    .wdata     (bus_wdata),
    .ctrl_mis  (ctrl_mis),
    .wdata_mis (wdata_mis)
  );

  apbmon_xfer_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk   (clk),
    .rst   (rst),
    .inc   ((cur_phase == PH_ACCESS) && bus_ready),
    .count (xfer_count)
  );

  always_comb begin
    err_now           = seq_err;
    err_now[ERR_CTRL]  = ctrl_mis;
    err_now[ERR_WDATA] = wdata_mis;
  end

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             err_sticky[i] <= 1'b0;
      else if (err_now[i]) err_sticky[i] <= 1'b1;
    end

    // R10: once raised, a flag stays raised until reset
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      err_sticky[i] |=> err_sticky[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= |err_now;
  end

  // R11: a pulse always comes with at least one raised flag
  p_pulse_flag_r11: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (|err_sticky));

  // R2: select low with enable high is flagged next cycle
  p_illegal_enc_r2: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel && bus_enable) |=> err_sticky[ERR_ENCODING]);

  // R3: setup not followed by access is flagged
  p_setup_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_sel && !bus_enable) && !(bus_sel && bus_enable))
    |=> err_sticky[ERR_SETUPLEN]);

  // R5: leaving a stalled access is flagged
  p_early_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_sel && bus_enable && !bus_ready) &&
     !(bus_sel && bus_enable)) |=> err_sticky[ERR_EARLY]);

  // R8: access straight after a completing access is flagged
  p_post_complete_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_sel && bus_enable && bus_ready) &&
     bus_sel && bus_enable) |=> err_sticky[ERR_POST]);

  // R9: a completing access bumps the count by one
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_enable && bus_ready) |=>
    (xfer_count == CNT_W'($past(xfer_count) + 1'b1)));

  // R9: without a completing access the count holds
  p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_enable && bus_ready) |=> $stable(xfer_count));

endmodule

// File: tb/apb_protocol_monitor_tb.sv
`timescale 1ns/1ps
module apb_protocol_monitor_tb;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0;
  logic              bus_enable = 1'b0;
  logic              bus_ready = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_write = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [6:0]        err_sticky;
  logic              err_pulse;
  logic [CNT_W-1:0]  xfer_count;

  apb_protocol_monitor #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_ready  (bus_ready),
    .bus_addr   (bus_addr),
    .bus_write  (bus_write),
    .bus_wdata  (bus_wdata),
    .err_sticky (err_sticky),
    .err_pulse  (err_pulse),
    .xfer_count (xfer_count)
  );

  always #5 clk = ~clk;

  typedef struct {
    int               due;
    logic [6:0]       fl;
    logic             pu;
    logic [CNT_W-1:0] cnt;
    string            tag;
  } item_t;

  item_t            sb[$];
  int               cyc = 0;
  int               checks = 0;
  int               fails = 0;
  logic [6:0]       exp_fl = '0;
  logic [CNT_W-1:0] exp_cnt = '0;
  bit               finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs against the queued expectation for this cycle
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (err_sticky !== it.fl || err_pulse !== it.pu || xfer_count !== it.cnt) begin
        fails++;
        $display("FAIL %s: flags=%b/%b pulse=%b/%b count=%0d/%0d (actual/expected)",
                 it.tag, err_sticky, it.fl, err_pulse, it.pu, xfer_count, it.cnt);
      end
    end
  end

  task automatic push(input logic pu, input string tag);
    item_t it;
    it.due = cyc + 1;
    it.fl  = exp_fl;
    it.pu  = pu;
    it.cnt = exp_cnt;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bus_sel = 1'b0; bus_enable = 1'b0; bus_ready = 1'b0;
    bus_addr = '0; bus_write = 1'b0; bus_wdata = '0;
    exp_fl = '0;
    exp_cnt = '0;
    push(1'b0, "R1 reset");
  endtask

  task automatic step(input logic s, input logic e, input logic r,
                      input logic [ADDR_W-1:0] a, input logic w,
                      input logic [DATA_W-1:0] d, input logic [6:0] newerr,
                      input string tag);
    @(negedge clk);
    rst = 1'b0;
    bus_sel = s; bus_enable = e; bus_ready = r;
    bus_addr = a; bus_write = w; bus_wdata = d;
    exp_fl = exp_fl | newerr;
    if (s && e && r) exp_cnt = exp_cnt + 1'b1;
    push(newerr != 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    do_reset();

    // good write with one wait state
    step(0,0,1,8'h10,0,16'h1111,7'h00,"R12 idle noise");
    step(1,0,0,8'h05,1,16'h00AA,7'h00,"R2 setup");
    step(1,1,0,8'h05,1,16'h00AA,7'h00,"R6 stall stable");
    step(1,1,1,8'h05,1,16'h00AA,7'h00,"R9 complete");
    step(0,0,0,8'h00,0,16'h0000,7'h00,"R9 count held");

    // back-to-back reads
    step(1,0,0,8'h21,0,16'h0,7'h00,"R2 b2b setup");
    step(1,1,1,8'h21,0,16'h0,7'h00,"R9 b2b first");
    step(1,0,0,8'h22,0,16'h0,7'h00,"R8 setup after done");
    step(1,1,1,8'h22,0,16'h0,7'h00,"R9 b2b second");
    step(0,0,0,8'h00,0,16'h0,7'h00,"R9 b2b idle");

    // R12 idle activity ignored
    step(0,0,1,8'h33,1,16'h1234,7'h00,"R12 idle a");
    step(0,0,0,8'hC4,0,16'hFFFF,7'h00,"R12 idle b");
    step(0,0,1,8'h7E,1,16'h0001,7'h00,"R12 idle c");

    // R2 illegal encoding, R10 stickiness, R11 pulse width
    do_reset();
    step(0,1,0,8'h00,0,16'h0,7'h01,"R2 illegal encoding");
    step(0,0,0,8'h00,0,16'h0,7'h00,"R11 pulse drops");
    step(1,0,0,8'h01,0,16'h0,7'h00,"R10 sticky setup");
    step(1,1,1,8'h01,0,16'h0,7'h00,"R10 sticky access");
    step(0,0,0,8'h00,0,16'h0,7'h00,"R10 sticky idle");

    // R3 long setup
    do_reset();
    step(1,0,0,8'h02,0,16'h0,7'h00,"R3 setup one");
    step(1,0,0,8'h02,0,16'h0,7'h02,"R3 setup two");
    step(1,1,1,8'h02,0,16'h0,7'h00,"R3 then access");
    step(0,0,0,8'h00,0,16'h0,7'h00,"R3 idle");

    // R4 access without setup
    do_reset();
    step(0,0,0,8'h00,0,16'h0,7'h00,"R4 idle");
    step(1,1,1,8'h03,0,16'h0,7'h04,"R4 access from idle");
    step(0,0,0,8'h00,0,16'h0,7'h00,"R4 idle after");

    // R5 early exit
    do_reset();
    step(1,0,0,8'h04,0,16'h0,7'h00,"R5 setup");
    step(1,1,0,8'h04,0,16'h0,7'h00,"R5 stall");
    step(0,0,0,8'h04,0,16'h0,7'h08,"R5 left early");

    // R6 address change during stall
    do_reset();
    step(1,0,0,8'h01,0,16'h0,7'h00,"R6 setup");
    step(1,1,0,8'h01,0,16'h0,7'h00,"R6 stall same");
    step(1,1,1,8'h02,0,16'h0,7'h10,"R6 address moved");
    step(0,0,0,8'h00,0,16'h0,7'h00,"R6 idle");

    // R6 direction change during stall
    do_reset();
    step(1,0,0,8'h09,1,16'h5,7'h00,"R6 dir setup");
    step(1,1,0,8'h09,0,16'h5,7'h10,"R6 dir flipped");
    step(1,1,1,8'h09,0,16'h5,7'h10,"R6 dir still flipped");
    step(0,0,0,8'h00,0,16'h0,7'h00,"R6 dir idle");

    // R7 write data change on a write
    do_reset();
    step(1,0,0,8'h0A,1,16'h0001,7'h00,"R7 setup");
    step(1,1,0,8'h0A,1,16'h0002,7'h20,"R7 data moved");
    step(1,1,1,8'h0A,1,16'h0002,7'h20,"R7 data still moved");
    step(0,0,0,8'h00,0,16'h0000,7'h00,"R7 idle");

    // R7 write data ignored on a read
    do_reset();
    step(1,0,0,8'h0B,0,16'h0001,7'h00,"R7 read setup");
    step(1,1,0,8'h0B,0,16'h0009,7'h00,"R7 read data free");
    step(1,1,1,8'h0B,0,16'h0003,7'h00,"R7 read complete");
    step(0,0,0,8'h00,0,16'h0000,7'h00,"R7 read idle");

    // R8 access held after completion
    do_reset();
    step(1,0,0,8'h0C,0,16'h0,7'h00,"R8 setup");
    step(1,1,1,8'h0C,0,16'h0,7'h00,"R8 complete");
    step(1,1,1,8'h0C,0,16'h0,7'h40,"R8 access after done");
    step(0,0,0,8'h00,0,16'h0,7'h00,"R8 idle");

    // R9 counter wrap with seventeen transfers
    do_reset();
    for (int k = 0; k < 17; k++) begin
      step(1,0,0,8'(k),1,16'(k),7'h00,"R9 wrap setup");
      step(1,1,1,8'(k),1,16'(k),7'h00,"R9 wrap access");
    end
    step(0,0,0,8'h00,0,16'h0,7'h00,"R9 wrapped");

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule